// File: doc/BRIEF.md
# Serial Transmitter with Clear-to-Send Gating

This block turns bytes written by a host into an asynchronous serial stream. Bytes go into a 16-entry queue. A shifter takes them one at a time and sends each as a ten-bit character at a bit rate set by a 16x oversampling tick. The character format is fixed: one start bit, eight data bits and one stop bit, with no parity.

When hardware flow control is switched on, the shifter obeys the active-low clear-to-send input. An idle shifter starts a character only on a baud tick where the input is active. A shifter that is already sending makes the go/no-go decision for the following character at the centre of the stop bit. A character that has started always runs to the end of its stop bit.

Every change on clear-to-send is latched as a delta flag, which the host clears with an acknowledge strobe. The flag drives the interrupt request only when the interrupt is enabled and flow control is off. This keeps the automatic gating from sending a stream of interrupts to the host.

Top module: `uart_tx_cts`

## Requirements
- R1: Idle line is 1. A character is a start bit of 0, then data bits 0 through 7 (least significant first), then a stop bit of 1. Each bit lasts 16 baud ticks.
- R2: The queue holds 16 bytes and `fifo_full` is 1 while all 16 are occupied. A write while full is dropped: that byte is never transmitted.
- R3: With `auto_cts_en`=1 and the shifter idle with data queued, a character starts only on a baud tick where the synchronized `cts_n` (two clock stages) is 0.
- R4: With `auto_cts_en`=1, `cts_n` is sampled at the stop-bit centre. If it is 1 there, the next queued byte does not start. If it is 0 there, the next byte starts right after the stop bit, even if `cts_n` rises later in that stop bit.
- R5: Raising `cts_n` during a character does not shorten it. All data bits and the stop bit are still sent.
- R6: With `auto_cts_en`=0, queued bytes are sent whatever the level of `cts_n`.
- R7: Any change of the synchronized `cts_n` sets a delta flag, and `msi_ack` clears it. `msi_irq` = flag AND `msi_en` AND NOT `auto_cts_en`.
- R8: `tx_idle` is 1 only when the queue is empty and no character is being shifted. `fifo_empty` is 1 when the queue holds no byte.
- R9: After reset: `tx`=1, `fifo_empty`=1, `fifo_full`=0, `tx_idle`=1, `msi_irq`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Byte to queue |
| baud_tick | input | 1 | One-cycle 16x bit-rate enable |
| cts_n | input | 1 | Clear-to-send, active low, asynchronous |
| auto_cts_en | input | 1 | Hardware flow-control enable |
| msi_en | input | 1 | CTS-change interrupt enable |
| msi_ack | input | 1 | Clears the CTS delta flag |
| tx | output | 1 | Serial output |
| fifo_empty | output | 1 | Queue holds no byte |
| fifo_full | output | 1 | Queue holds 16 bytes |
| tx_idle | output | 1 | Queue empty and shifter idle |
| msi_irq | output | 1 | CTS-change interrupt request |

## Verification
The embedded assertions check these properties on every cycle:
- occupancy never exceeds the depth, and a write while full does not leave the full state;
- no pop happens from an empty queue;
- an idle-state start never happens while flow control is on and clear-to-send is inactive;
- a character in its data or stop phase never drops back to idle;
- every synchronized CTS edge leaves the delta flag set;
- the line is high whenever the transmitter is idle.

The directed scenarios are the only way to show the rest:
- the bit order and bit length on the line;
- the loss of a byte written to a full queue;
- which side of the stop-bit centre a CTS change must fall on to hold back the next byte;
- the masking of the interrupt while flow control is on.

// File: rtl/uart_tx_pkg.sv
// Shared types for the serial transmitter.
package uart_tx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } tx_state_e;
endpackage

// File: rtl/tx_fifo.sv
// Byte queue for the transmitter. Single clock, first-word fall-through.
// Assumes: rd_en is raised only when the queue is not empty. A write while
// full is dropped.
module tx_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             empty,
    output logic             full
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    count;
    logic             wr_ok, rd_ok;

    assign wr_ok   = wr_en && !full;
    assign rd_ok   = rd_en && !empty;
    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign rd_data = mem[rd_ptr];

    // Storage write: accepted bytes go into the slot at the write pointer.
    always_ff @(posedge clk) begin
        if (wr_ok) mem[wr_ptr] <= wr_data;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_ok) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            if (rd_ok) rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            case ({wr_ok, rd_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    assert_full_write_dropped_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !rd_en) |=> full);
endmodule

// File: rtl/cts_watch.sv
// Synchronizes the asynchronous active-low clear-to-send input and keeps the
// delta flag. The interrupt is masked while hardware flow control is on.
// Assumes: cts_n may change at any time. The chain resets to inactive.
module cts_watch #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cts_n,
    input  logic auto_cts_en,
    input  logic msi_en,
    input  logic msi_ack,
    output logic cts_active,
    output logic msi_irq
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   dcts_q;
    logic                   cts_sync;

    assign cts_sync   = sync_q[SYNC_STAGES-1];
    assign cts_active = !cts_sync;

    // Synchronizer chain for the asynchronous input.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], cts_n};
    end

    // Edge history and delta flag. A new edge wins over an acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
            dcts_q <= 1'b0;
        end else begin
            prev_q <= cts_sync;
            if (prev_q != cts_sync) dcts_q <= 1'b1;
            else if (msi_ack)       dcts_q <= 1'b0;
        end
    end

    assign msi_irq = dcts_q && msi_en && !auto_cts_en;

    assert_delta_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_q != cts_sync) |=> dcts_q);
endmodule

// File: rtl/tx_shifter.sv
// Character shifter: start bit, WIDTH data bits (LSB first), one stop bit,
// each TICKS_PER_BIT baud ticks long. Under flow control the start from
// idle is gated by CTS on each tick. A back-to-back start is gated by CTS
// as sampled at the stop-bit centre. A started character always completes.
// Assumes: baud_tick is a one-cycle pulse, and fifo_data is valid whenever
// fifo_empty is low.
module tx_shifter
    import uart_tx_pkg::*;
#(
    parameter int WIDTH         = 8,
    parameter int TICKS_PER_BIT = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             baud_tick,
    input  logic             fifo_empty,
    input  logic [WIDTH-1:0] fifo_data,
    input  logic             cts_active,
    input  logic             auto_cts_en,
    output logic             pop,
    output logic             tx,
    output logic             busy
);
    localparam int TW = $clog2(TICKS_PER_BIT);
    localparam int BW = $clog2(WIDTH);
    localparam logic [TW-1:0] LAST_TICK = TW'(TICKS_PER_BIT - 1);
    localparam logic [TW-1:0] MID_TICK  = TW'(TICKS_PER_BIT / 2 - 1);
    localparam logic [BW-1:0] LAST_BIT  = BW'(WIDTH - 1);

    tx_state_e        state_q, state_d;
    logic [TW-1:0]    tick_q;
    logic [BW-1:0]    bit_q;
    logic [WIDTH-1:0] shreg_q;
    logic             go_next_q;
    logic             cts_ok, last_tick, mid_tick, start_idle, start_b2b;

    assign cts_ok     = !auto_cts_en || cts_active;
    assign last_tick  = baud_tick && (tick_q == LAST_TICK);
    assign mid_tick   = baud_tick && (tick_q == MID_TICK);
    assign start_idle = (state_q == ST_IDLE) && baud_tick && !fifo_empty && cts_ok;
    assign start_b2b  = (state_q == ST_STOP) && last_tick && !fifo_empty && go_next_q;
    assign pop        = start_idle || start_b2b;
    assign busy       = (state_q != ST_IDLE);

    // Next-state selection for the character sequence.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:  if (start_idle) state_d = ST_START;
            ST_START: if (last_tick) state_d = ST_DATA;
            ST_DATA:  if (last_tick && bit_q == LAST_BIT) state_d = ST_STOP;
            ST_STOP:  if (last_tick) state_d = start_b2b ? ST_START : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Line level for the current phase.
    always_comb begin
        case (state_q)
            ST_START: tx = 1'b0;
            ST_DATA:  tx = shreg_q[0];
            default:  tx = 1'b1;
        endcase
    end

    // State, tick counter, bit index, shift register and stop-centre CTS sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            tick_q    <= '0;
            bit_q     <= '0;
            shreg_q   <= '0;
            go_next_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (pop) begin
                tick_q  <= '0;
                bit_q   <= '0;
                shreg_q <= fifo_data;
            end else if (busy && baud_tick) begin
                tick_q <= last_tick ? '0 : tick_q + 1'b1;
                if (state_q == ST_DATA && last_tick) begin
                    shreg_q <= shreg_q >> 1;
                    bit_q   <= bit_q + 1'b1;
                end
            end
            if (state_q == ST_STOP && mid_tick) go_next_q <= cts_ok;
        end
    end

    assert_idle_start_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && state_d == ST_START && auto_cts_en) |-> cts_active);
    assert_no_abort_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA) |=> (state_q == ST_DATA || state_q == ST_STOP));
    assert_stop_completes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP && !baud_tick) |=> (state_q == ST_STOP));
    assert_pop_nonempty_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !fifo_empty);
endmodule

// File: rtl/uart_tx_cts.sv
// Top of the serial transmitter: byte queue, character shifter and CTS
// watcher. Assumes: a single clock domain except the cts_n input, which is
// synchronized inside. baud_tick is generated outside the block.
module uart_tx_cts #(
    parameter int WIDTH         = 8,
    parameter int DEPTH         = 16,
    parameter int TICKS_PER_BIT = 16,
    parameter int SYNC_STAGES   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             baud_tick,
    input  logic             cts_n,
    input  logic             auto_cts_en,
    input  logic             msi_en,
    input  logic             msi_ack,
    output logic             tx,
    output logic             fifo_empty,
    output logic             fifo_full,
    output logic             tx_idle,
    output logic             msi_irq
);
    logic [WIDTH-1:0] head_data;
    logic             pop, busy, cts_active;

    tx_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(pop), .rd_data(head_data), .empty(fifo_empty), .full(fifo_full)
    );

    cts_watch #(.SYNC_STAGES(SYNC_STAGES)) u_cts (
        .clk(clk), .rst_n(rst_n), .cts_n(cts_n), .auto_cts_en(auto_cts_en),
        .msi_en(msi_en), .msi_ack(msi_ack), .cts_active(cts_active), .msi_irq(msi_irq)
    );

    tx_shifter #(.WIDTH(WIDTH), .TICKS_PER_BIT(TICKS_PER_BIT)) u_shift (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .fifo_empty(fifo_empty),
        .fifo_data(head_data), .cts_active(cts_active), .auto_cts_en(auto_cts_en),
        .pop(pop), .tx(tx), .busy(busy)
    );

    assign tx_idle = fifo_empty && !busy;

    assert_idle_line_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_idle |-> tx);
endmodule

// File: tb/uart_tx_cts_bench.sv
`timescale 1ns/1ps
module uart_tx_cts_bench;
    localparam int TICK_DIV = 4;
    localparam int BIT      = 16 * TICK_DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       baud_tick = 1'b0;
    logic       cts_n = 1'b1;
    logic       auto_cts_en = 1'b0;
    logic       msi_en = 1'b0;
    logic       msi_ack = 1'b0;
    logic       tx, fifo_empty, fifo_full, tx_idle, msi_irq;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    int tick_cnt = 0;

    uart_tx_cts u_uart_tx_cts (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .baud_tick(baud_tick), .cts_n(cts_n), .auto_cts_en(auto_cts_en),
        .msi_en(msi_en), .msi_ack(msi_ack), .tx(tx), .fifo_empty(fifo_empty),
        .fifo_full(fifo_full), .tx_idle(tx_idle), .msi_irq(msi_irq)
    );

    always #4 clk = ~clk;

    // Baud tick: one cycle in every TICK_DIV, driven away from the active edge.
    always @(negedge clk) begin
        tick_cnt  <= (tick_cnt == TICK_DIV-1) ? 0 : tick_cnt + 1;
        baud_tick <= (tick_cnt == TICK_DIV-1);
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] b);
        @(negedge clk); wr_en = 1'b1; wr_data = b;
        @(negedge clk); wr_en = 1'b0;
    endtask

    // Waits for a start bit, then samples each bit at its centre. drop_at
    // raises cts_n after data bit drop_at (0..7), or 8 = a quarter bit after
    // the stop-bit centre.
    task automatic get_frame(output logic [7:0] b, output bit found, output bit stop_ok,
                             input int drop_at);
        int waited = 0;
        found = 0; stop_ok = 0; b = 8'h00;
        while (tx !== 1'b0 && waited < 6*BIT) begin
            @(negedge clk); waited++;
        end
        if (tx !== 1'b0) return;
        found = 1;
        repeat (BIT/2) @(negedge clk);
        check(tx === 1'b0, "R1 start bit", tx, 0);
        for (int i = 0; i < 8; i++) begin
            repeat (BIT) @(negedge clk);
            b[i] = tx;
            if (drop_at == i) cts_n = 1'b1;
        end
        repeat (BIT) @(negedge clk);
        stop_ok = (tx === 1'b1);
        if (drop_at == 8) begin
            repeat (BIT/4) @(negedge clk);
            cts_n = 1'b1;
        end
    endtask

    task automatic expect_frame(input logic [7:0] exp, input string req, input int drop_at);
        logic [7:0] b; bit f, s;
        get_frame(b, f, s, drop_at);
        check(f, {req, " frame started"}, f, 1);
        check(b == exp, {req, " data"}, b, exp);
        check(s, {req, " stop bit"}, s, 1);
    endtask

    task automatic wait_idle();
        int n = 0;
        while (!tx_idle && n < 40*BIT) begin @(negedge clk); n++; end
        repeat (BIT) @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(tx === 1'b1, "R9 tx", tx, 1);
        check(fifo_empty === 1'b1, "R9 empty", fifo_empty, 1);
        check(fifo_full === 1'b0, "R9 full", fifo_full, 0);
        check(tx_idle === 1'b1, "R9 idle", tx_idle, 1);
        check(msi_irq === 1'b0, "R9 irq", msi_irq, 0);
    endtask

    task automatic t_single();
        auto_cts_en = 1'b0; cts_n = 1'b0;
        put(8'hA5);
        check(tx_idle === 1'b0, "R8 idle low with data", tx_idle, 0);
        expect_frame(8'hA5, "R1", -1);
        repeat (BIT) @(negedge clk);
        check(tx_idle === 1'b1 && tx === 1'b1, "R8 idle after frame", tx_idle, 1);
    endtask

    task automatic t_no_auto();
        auto_cts_en = 1'b0; cts_n = 1'b1;
        put(8'h5A);
        expect_frame(8'h5A, "R6", -1);
        wait_idle();
    endtask

    task automatic t_fill();
        logic [7:0] b; bit f, s;
        auto_cts_en = 1'b1; cts_n = 1'b1;
        repeat (4) @(negedge clk);
        for (int i = 0; i < 16; i++) put(8'h10 + 8'(i));
        check(fifo_full === 1'b1, "R2 full at 16", fifo_full, 1);
        put(8'hEE);
        repeat (4*BIT) @(negedge clk);
        check(tx === 1'b1 && fifo_full === 1'b1, "R3 held while CTS inactive", tx, 1);
        check(tx_idle === 1'b0, "R8 idle low while blocked", tx_idle, 0);
        cts_n = 1'b0;
        for (int i = 0; i < 16; i++) expect_frame(8'h10 + 8'(i), "R2 drain", -1);
        get_frame(b, f, s, -1);
        check(!f, "R2 dropped byte never sent", f, 0);
        check(fifo_empty === 1'b1 && tx_idle === 1'b1, "R8 empty after drain", fifo_empty, 1);
    endtask

    task automatic t_mid_char();
        auto_cts_en = 1'b1; cts_n = 1'b0;
        put(8'h3C); put(8'hC3);
        expect_frame(8'h3C, "R5 full char despite CTS drop", 3);
        for (int i = 0; i < 3*BIT; i++) begin
            @(negedge clk);
            if (tx !== 1'b1) begin
                check(0, "R4 next byte held", tx, 1);
                break;
            end
        end
        check(fifo_empty === 1'b0, "R4 byte still queued", fifo_empty, 0);
        cts_n = 1'b0;
        expect_frame(8'hC3, "R3 resume on CTS", -1);
        wait_idle();
    endtask

    task automatic t_after_mid();
        auto_cts_en = 1'b1; cts_n = 1'b0;
        put(8'h81); put(8'h7E);
        expect_frame(8'h81, "R4 first", 8);
        expect_frame(8'h7E, "R4 started after late CTS drop", -1);
        cts_n = 1'b0;
        wait_idle();
    endtask

    task automatic t_irq();
        auto_cts_en = 1'b0; msi_en = 1'b1;
        @(negedge clk); msi_ack = 1'b1; @(negedge clk); msi_ack = 1'b0;
        cts_n = ~cts_n;
        repeat (5) @(negedge clk);
        check(msi_irq === 1'b1, "R7 irq on change", msi_irq, 1);
        msi_ack = 1'b1; @(negedge clk); msi_ack = 1'b0;
        @(negedge clk);
        check(msi_irq === 1'b0, "R7 ack clears", msi_irq, 0);
        auto_cts_en = 1'b1;
        cts_n = ~cts_n;
        repeat (5) @(negedge clk);
        check(msi_irq === 1'b0, "R7 masked under flow control", msi_irq, 0);
        auto_cts_en = 1'b0;
        @(negedge clk);
        check(msi_irq === 1'b1, "R7 flag latched while masked", msi_irq, 1);
        msi_en = 1'b0;
        @(negedge clk);
        check(msi_irq === 1'b0, "R7 enable off", msi_irq, 0);
        msi_ack = 1'b1; @(negedge clk); msi_ack = 1'b0;
    endtask

    initial begin
        t_reset();
        t_single();
        t_no_auto();
        t_fill();
        t_mid_char();
        t_after_mid();
        t_irq();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule